// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block controls the loop behind a repeated string instruction. A start pulse loads the iteration count and latches three settings: the low bit of the repeat prefix, whether the string operation writes flags, and the width of the count register. The block then requests one step at a time from an external datapath. Each step-done handshake returns the zero flag that the step produced. After every completed step the block decrements the count and decides whether the loop is finished.

The loop always ends when the count reaches zero. For string operations that write flags, it also ends as soon as the returned zero flag differs from the latched prefix bit. A prefix bit of 1 therefore stops on ZF=0, and a prefix bit of 0 stops on ZF=1. For operations that leave flags alone, both repeat prefixes give a plain counted loop. A one-cycle done pulse reports the cause as two bits, and the remaining count stays on the output until the next start.

Top module: `rep_string_ctrl`

## Requirements
- R1: A start pulse while idle, with a non-zero effective count, raises busy_o and step_req_o in the next cycle. step_req_o stays high only while busy_o is high.
- R2: Each accepted step (step_req_o and step_done_i high at a clock edge) lowers cnt_o by exactly one in the following cycle, including the final step.
- R3: The loop ends when the decremented count is zero, whatever ZF holds. cause_o bit 0 (count exhausted) is then set and cnt_o reads 0.
- R4: When flag_op_i was low at start, step_zf_i has no effect. Both prefix bit values give exactly count steps, and cause_o is 2'b01.
- R5: When flag_op_i and pfx_lsb_i were high at start, a step returning ZF=0 ends the loop with cause_o bit 1 (ZF condition) set.
- R6: When flag_op_i was high and pfx_lsb_i low at start, a step returning ZF=1 ends the loop with cause_o bit 1 set.
- R7: When the count reaches zero and the ZF condition holds on the same step, cause_o is 2'b11.
- R8: A start with an effective count of zero issues no step request. It gives done_o in the next cycle with busy_o low, cause_o 2'b01 and cnt_o 0.
- R9: With wide_cnt_i low (16-bit count), only the low 16 bits of cnt_init_i are used and the upper 16 bits of cnt_o stay zero. With wide_cnt_i high, all 32 bits are used.
- R10: done_o is high for exactly one cycle, in the cycle after the final step, with busy_o low. cnt_o and cause_o keep their final values until the next start.
- R11: A start pulse while busy is ignored: the running loop's count, steps and result are unchanged.
- R12: After reset, busy_o, step_req_o, done_o, cnt_o and cause_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a loop (used only while idle) |
| pfx_lsb_i | input | 1 | Bit 0 of the repeat prefix |
| flag_op_i | input | 1 | String operation writes flags |
| cnt_init_i | input | 32 | Initial count value |
| wide_cnt_i | input | 1 | 1: 32-bit count, 0: 16-bit count |
| step_req_o | output | 1 | Request one datapath step |
| step_done_i | input | 1 | Datapath step completed |
| step_zf_i | input | 1 | ZF produced by the completed step |
| cnt_o | output | 32 | Remaining count |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| cause_o | output | 2 | bit0 count exhausted, bit1 ZF condition |

## Verification
busy_o and step_req_o are due one cycle after the start edge. The cnt_o decrement is due one cycle after each accepted step, and done_o with cause_o is due one cycle after the final step (or after the start edge for a zero count). The bench drives inputs and samples outputs on the falling edge. Its step responder records cnt_o when it raises step_done_i and compares it one falling edge later. The monitor pops the scoreboard entry on the falling edge where done_o is seen, and the driver rechecks the held result a few cycles later.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int CAUSE_W   = 2;
  localparam int CAUSE_CNT = 0;
  localparam int CAUSE_ZF  = 1;
endpackage

// File: rtl/rep_cnt_unit.sv
module rep_cnt_unit #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             wide_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_zero_o,
  output logic             dec_zero_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] size_mask(input logic [CNT_W-1:0] v,
                                                 input logic w);
    logic [CNT_W-1:0] m;
    m = '0;
    m[NARROW_W-1:0] = '1;
    return w ? v : (v & m);
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic [CNT_W-1:0] init_eff;
  logic [CNT_W-1:0] cnt_q;

  assign init_eff = size_mask(init_i, wide_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= init_eff;
    else if (dec_i)  cnt_q <= step_down(cnt_q);
  end

  assign cnt_o       = cnt_q;
  assign load_zero_o = (init_eff == '0);
  assign dec_zero_o  = (step_down(cnt_q) == '0);
endmodule

// File: rtl/rep_stop_eval.sv
module rep_stop_eval
  import rep_pkg::*;
(
  input  logic               flag_op_i,
  input  logic               pfx_lsb_i,
  input  logic               zf_i,
  input  logic               cnt_zero_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               stop_o
);
  function automatic logic zf_mismatch(input logic flag_op, input logic pfx,
                                       input logic zf);
    return flag_op && (zf != pfx);
  endfunction

  always_comb begin
    cause_o            = '0;
    cause_o[CAUSE_CNT] = cnt_zero_i;
    cause_o[CAUSE_ZF]  = zf_mismatch(flag_op_i, pfx_lsb_i, zf_i);
    stop_o             = |cause_o;
  end
endmodule

// File: rtl/rep_seq_fsm.sv
module rep_seq_fsm
  import rep_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               pfx_lsb_i,
  input  logic               flag_op_i,
  input  logic               wide_i,
  input  logic               load_zero_i,
  input  logic               step_done_i,
  input  logic               stop_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               busy_o,
  output logic               step_req_o,
  output logic               done_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               load_o,
  output logic               step_fire_o,
  output logic               pfx_q_o,
  output logic               flag_q_o,
  output logic               wide_q_o
);
  seq_state_e         state_q;
  logic               done_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               pfx_q, flag_q, wide_q;

  assign load_o      = (state_q == SEQ_IDLE) && start_i;
  assign step_fire_o = (state_q == SEQ_RUN) && step_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      cause_q <= '0;
      pfx_q   <= 1'b0;
      flag_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        pfx_q  <= pfx_lsb_i;
        flag_q <= flag_op_i;
        wide_q <= wide_i;
        if (load_zero_i) begin
          done_q             <= 1'b1;
          cause_q            <= '0;
          cause_q[CAUSE_CNT] <= 1'b1;
        end else begin
          state_q <= SEQ_RUN;
          cause_q <= '0;
        end
      end else if (step_fire_o && stop_i) begin
        state_q <= SEQ_IDLE;
        done_q  <= 1'b1;
        cause_q <= cause_i;
      end
    end
  end

  assign busy_o     = (state_q == SEQ_RUN);
  assign step_req_o = (state_q == SEQ_RUN);
  assign done_o     = done_q;
  assign cause_o    = cause_q;
  assign pfx_q_o    = pfx_q;
  assign flag_q_o   = flag_q;
  assign wide_q_o   = wide_q;
endmodule

// File: rtl/rep_string_ctrl.sv
module rep_string_ctrl
  import rep_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               pfx_lsb_i,
  input  logic               flag_op_i,
  input  logic [CNT_W-1:0]   cnt_init_i,
  input  logic               wide_cnt_i,
  output logic               step_req_o,
  input  logic               step_done_i,
  input  logic               step_zf_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [CAUSE_W-1:0] cause_o
);
  // named internal events, used by the bound checker
  logic               load_fire;
  logic               step_fire;
  logic               init_zero;
  logic               dec_zero;
  logic               stop_now;
  logic [CAUSE_W-1:0] cause_now;
  logic               cfg_pfx, cfg_flag, cfg_wide;

  rep_cnt_unit #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_fire),
    .init_i      (cnt_init_i),
    .wide_i      (wide_cnt_i),
    .dec_i       (step_fire),
    .cnt_o       (cnt_o),
    .load_zero_o (init_zero),
    .dec_zero_o  (dec_zero)
  );

  rep_stop_eval stop_i (
    .flag_op_i  (cfg_flag),
    .pfx_lsb_i  (cfg_pfx),
    .zf_i       (step_zf_i),
    .cnt_zero_i (dec_zero),
    .cause_o    (cause_now),
    .stop_o     (stop_now)
  );

  rep_seq_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pfx_lsb_i   (pfx_lsb_i),
    .flag_op_i   (flag_op_i),
    .wide_i      (wide_cnt_i),
    .load_zero_i (init_zero),
    .step_done_i (step_done_i),
    .stop_i      (stop_now),
    .cause_i     (cause_now),
    .busy_o      (busy_o),
    .step_req_o  (step_req_o),
    .done_o      (done_o),
    .cause_o     (cause_o),
    .load_o      (load_fire),
    .step_fire_o (step_fire),
    .pfx_q_o     (cfg_pfx),
    .flag_q_o    (cfg_flag),
    .wide_q_o    (cfg_wide)
  );
endmodule

// File: rtl/rep_string_ctrl_chk.sv
module rep_string_ctrl_chk #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             step_req_o,
  input logic             step_done_i,
  input logic             step_zf_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       cause_o,
  input logic             load_fire,
  input logic             step_fire,
  input logic             init_zero,
  input logic             cfg_pfx,
  input logic             cfg_flag,
  input logic             cfg_wide
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_req_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |-> busy_o);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && !init_zero |=> busy_o && step_req_o);

  p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o && step_done_i |=> cnt_o == $past(cnt_o) - ONE);

  p_cnt_end_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cause_o[0] |-> cnt_o == '0);

  p_zf_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && !cfg_flag |=> !cause_o[1]);

  p_zf_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && cfg_flag && (step_zf_i != cfg_pfx) |=> done_o && cause_o[1]);

  p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && init_zero |=> done_o && !busy_o && cause_o == 2'b01);

  p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> cnt_o[CNT_W-1:NARROW_W] == '0);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !step_done_i |=> $stable(cnt_o));
endmodule

bind rep_string_ctrl rep_string_ctrl_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .step_req_o  (step_req_o),
  .step_done_i (step_done_i),
  .step_zf_i   (step_zf_i),
  .cnt_o       (cnt_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cause_o     (cause_o),
  .load_fire   (load_fire),
  .step_fire   (step_fire),
  .init_zero   (init_zero),
  .cfg_pfx     (cfg_pfx),
  .cfg_flag    (cfg_flag),
  .cfg_wide    (cfg_wide)
);

// File: tb/rep_string_ctrl_tb_top.sv
`timescale 1ns/1ps
module rep_string_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        pfx_lsb_i = 1'b0;
  logic        flag_op_i = 1'b0;
  logic [31:0] cnt_init_i = '0;
  logic        wide_cnt_i = 1'b0;
  logic        step_req_o;
  logic        step_done_i = 1'b0;
  logic        step_zf_i = 1'b0;
  logic [31:0] cnt_o;
  logic        busy_o;
  logic        done_o;
  logic [1:0]  cause_o;

  always #2 clk = ~clk;

  rep_string_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pfx_lsb_i(pfx_lsb_i),
    .flag_op_i(flag_op_i), .cnt_init_i(cnt_init_i), .wide_cnt_i(wide_cnt_i),
    .step_req_o(step_req_o), .step_done_i(step_done_i), .step_zf_i(step_zf_i),
    .cnt_o(cnt_o), .busy_o(busy_o), .done_o(done_o), .cause_o(cause_o)
  );

  typedef struct {
    logic [31:0] cnt;
    logic [1:0]  cause;
    int          steps;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          n_issued = 0;
  int          n_seen = 0;
  int          step_idx = 0;
  logic [31:0] zf_pat = '0;
  bit          slow = 1'b0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent result model
  function automatic exp_t predict(bit pfx, bit flag, logic [31:0] init, bit wide,
                                   logic [31:0] pat, string tag);
    exp_t e;
    longint left;
    bit z, c_end, z_end;
    left = wide ? longint'(init) : longint'(init & 32'h0000_FFFF);
    e.steps = 0;
    e.tag = tag;
    e.cause = 2'b01;
    e.cnt = '0;
    if (left == 0) return e;
    while (1) begin
      z = pat[e.steps % 32];
      left = left - 1;
      e.steps++;
      c_end = (left == 0);
      z_end = flag && (z != pfx);
      if (c_end || z_end) begin
        e.cnt = left[31:0];
        e.cause = {z_end, c_end};
        break;
      end
    end
    return e;
  endfunction

  // driver: pushes the expectation, starts the loop, waits for its result
  task automatic run_op(bit pfx, bit flag, logic [31:0] init, bit wide,
                        logic [31:0] pat, bit slw, bit poke, string tag);
    exp_t e;
    e = predict(pfx, flag, init, wide, pat, tag);
    sb_q.push_back(e);
    n_issued++;
    zf_pat = pat;
    slow = slw;
    step_idx = 0;
    @(negedge clk);
    start_i = 1'b1; pfx_lsb_i = pfx; flag_op_i = flag;
    cnt_init_i = init; wide_cnt_i = wide;
    @(negedge clk);
    start_i = 1'b0;
    if (e.steps > 0)
      check(busy_o && step_req_o, {tag, " R1 busy after start"},
            {30'd0, busy_o, step_req_o}, 32'd3);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1; pfx_lsb_i = ~pfx; flag_op_i = 1'b0;
      cnt_init_i = 32'd2; wide_cnt_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (n_seen == n_issued);
    repeat (3) @(negedge clk);
    check(cnt_o == e.cnt && cause_o == e.cause && !done_o && !busy_o,
          {tag, " R10 result held"}, {cnt_o[29:0], cause_o}, {e.cnt[29:0], e.cause});
  endtask

  // step responder: answers requests with ZF taken from the pattern
  initial begin
    logic [31:0] seen_cnt;
    bit fired;
    bit phase;
    fired = 1'b0;
    phase = 1'b0;
    forever begin
      @(negedge clk);
      if (fired)
        check(cnt_o == seen_cnt - 32'd1, "R2 decrement", cnt_o, seen_cnt - 32'd1);
      fired = 1'b0;
      phase = ~phase;
      if (step_req_o && (!slow || phase)) begin
        step_done_i = 1'b1;
        step_zf_i = zf_pat[step_idx % 32];
        seen_cnt = cnt_o;
        fired = 1'b1;
        step_idx++;
      end else begin
        step_done_i = 1'b0;
        step_zf_i = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard when a loop ends
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          check(cnt_o == e.cnt, {e.tag, " final count"}, cnt_o, e.cnt);
          check(cause_o == e.cause, {e.tag, " cause"}, {30'd0, cause_o}, {30'd0, e.cause});
          check(step_idx == e.steps, {e.tag, " step count"}, step_idx, e.steps);
          check(!busy_o, {e.tag, " R10 idle at done"}, {31'd0, busy_o}, 32'd0);
        end
        n_seen++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !step_req_o && !done_o && cnt_o == 0 && cause_o == 0,
          "R12 reset state", {cnt_o[27:0], busy_o, step_req_o, cause_o}, 32'd0);

    run_op(1'b1, 1'b0, 32'd5,  1'b1, 32'h0000_0000, 1'b0, 1'b0, "R4 pfx1 plain");
    run_op(1'b0, 1'b0, 32'd5,  1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 pfx0 plain");
    run_op(1'b1, 1'b1, 32'd10, 1'b1, 32'hFFFF_FFF7, 1'b0, 1'b0, "R5 stop zf0");
    run_op(1'b0, 1'b1, 32'd10, 1'b1, 32'h0000_0020, 1'b0, 1'b0, "R6 stop zf1");
    run_op(1'b1, 1'b1, 32'd4,  1'b1, 32'hFFFF_FFF7, 1'b0, 1'b0, "R7 both");
    run_op(1'b1, 1'b1, 32'd3,  1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 count out");
    run_op(1'b0, 1'b1, 32'd0,  1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 zero count");
    run_op(1'b1, 1'b0, 32'h0001_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R9 narrow zero");
    run_op(1'b0, 1'b0, 32'hABCD_0003, 1'b0, 32'h0, 1'b0, 1'b0, "R9 narrow three");
    run_op(1'b0, 1'b1, 32'h0001_0002, 1'b1, 32'h0000_0004, 1'b0, 1'b0, "R9 wide");
    run_op(1'b1, 1'b0, 32'd6,  1'b1, 32'h0, 1'b1, 1'b0, "R2 slow steps");
    run_op(1'b1, 1'b1, 32'd8,  1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, "R11 start ignored");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule